// File: doc/BRIEF.md
# Configuration Sync Word Aligner

This block sits behind a parallel configuration port whose bus width has already been worked out. It takes beats of 8, 16 or 32 bits, turns them into a single byte stream, and hunts that stream for the 32-bit synchronisation pattern 0xAA995566. The pattern may start at any byte, so it may sit across two beats. Once the pattern is found, the block locks its word boundary to the end of the pattern. From then on it packs every four following bytes into one aligned 32-bit output word, marked with a one-cycle valid strobe.

A swap option reverses the bit order inside every byte before matching and before packing. With this option a bitstream written in the swapped format is handled like an unswapped one: at the pins its pattern reads 0x5599AA66. Until the width detector reports completion, incoming beats are discarded. A lock flag tells downstream logic that aligned words can now arrive.

Top module: `sync_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, `synced` and `word_valid` are both low after that edge.
- R2: `word_valid` is never high while `synced` is low, and the pattern bytes themselves never appear on `word_data`.
- R3: A beat presented while `width_ok` is low has no effect: it neither advances the pattern hunt nor contributes bytes to an output word.
- R4: The pattern 0xAA995566 (byte 0xAA first) is recognised starting at any byte position of the stream, for every width: `width_sel` 0 = x8, 1 = x16, 2 or 3 = x32. A partial match that breaks off does not stop a later full match.
- R5: When `swap_en` is high, each byte is bit-reversed (bit 7 to bit 0) before matching and before output, so an x32 beat of 0x5599AA66 locks the block.
- R6: The first output word consists of the four bytes that immediately follow the final pattern byte 0x66.
- R7: After lock, one word is produced per 4, 2 or 1 accepted beats for x8, x16 or x32 respectively, once the bytes carried over from the lock beat have been used up.
- R8: `synced` stays high until reset, and a second occurrence of the pattern after lock is forwarded as ordinary data.
- R9: Within a beat of N bytes, the byte on the highest lane (bits 8N-1:8N-8) comes first in the stream. In `word_data` the earliest byte is placed in bits 31:24.
- R10: `word_valid` rises in the cycle after the accepted beat that completes a word and lasts one cycle. A cycle with no accepted beat produces no word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_ok | input | 1 | Bus width detection has completed; beats are accepted only while high |
| width_sel | input | 2 | Detected width: 0 = x8, 1 = x16, 2 or 3 = x32 |
| swap_en | input | 1 | Reverse the bit order inside each byte |
| beat_valid | input | 1 | A beat is present on `beat_data` |
| beat_data | input | 32 | Beat; x8 uses bits 7:0, x16 uses bits 15:0 |
| word_valid | output | 1 | One-cycle strobe for an aligned output word |
| word_data | output | 32 | Aligned word, earliest byte in bits 31:24 |
| synced | output | 1 | Pattern found; sticky until reset |

## Verification
The bench attacks the cases where the pattern is split across beats: byte offsets 1 to 3 on x32, an odd offset on x16, and a false start (AA 99 55 AA 99 55 66) on x8. A design that compared only whole beats, or that restarted the hunt badly, would never lock or would lock late, and every later word would be shifted. Swapped streams catch a missing or misplaced bit reversal, which would leave the block unlocked. Beats sent before width detection catch a hunter that listens too early and would lock on a stream that should be ignored. A repeated pattern after lock checks that forwarding continues and is not swallowed or re-aligned. Idle gaps check the strobe timing and the carry-over of leftover bytes.

// File: rtl/sync_align_pkg.sv
package sync_align_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int HIST    = LANES - 1;
    localparam int MIX     = 2 * LANES - 1;
    localparam int CNT_W   = $clog2(LANES);
    localparam int LCNT_W  = $clog2(LANES + 1);

    localparam logic [WORD_W-1:0] SYNC_PATTERN = 32'hAA995566;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        BW_X8   = 2'd0,
        BW_X16  = 2'd1,
        BW_X32  = 2'd2,
        BW_X32B = 2'd3
    } bus_width_e;

    // Bytes of one beat in stream order: lane[0] is the earliest byte.
    typedef struct packed {
        logic [LCNT_W-1:0]      count;
        byte_t [LANES-1:0]      lane;
    } beat_bytes_t;

    function automatic byte_t rev_bits(input byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

    function automatic logic [LCNT_W-1:0] lanes_of(input bus_width_e w);
        case (w)
            BW_X8:   return LCNT_W'(1);
            BW_X16:  return LCNT_W'(2);
            default: return LCNT_W'(LANES);
        endcase
    endfunction

endpackage

// File: rtl/beat_unpack.sv
module beat_unpack
    import sync_align_pkg::*;
(
    input  bus_width_e              width,
    input  logic                    swap,
    input  logic [WORD_W-1:0]       data,
    output beat_bytes_t             bytes
);

    always_comb begin
        bytes       = '0;
        bytes.count = lanes_of(width);
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(bytes.count)) begin
                bytes.lane[i] = swap
                    ? rev_bits(data[BYTE_W*(int'(bytes.count)-1-i) +: BYTE_W])
                    : data[BYTE_W*(int'(bytes.count)-1-i) +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
    import sync_align_pkg::*;
#(
    parameter logic [WORD_W-1:0] SYNC_WORD = SYNC_PATTERN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                locked,
    input  beat_bytes_t         bytes,
    output logic                hit,
    output logic [CNT_W-1:0]    hit_pos
);

    byte_t              hist_q [HIST];
    byte_t              hist_n [HIST];
    byte_t              cat    [MIX];
    logic [WORD_W-1:0]  win    [LANES];
    logic [LANES-1:0]   match_vec;

    // Oldest history bytes first, then the new beat's bytes in stream order.
    always_comb begin
        for (int j = 0; j < MIX; j++) begin
            if (j < HIST) begin
                cat[j] = hist_q[j];
            end else if ((j - HIST) < int'(bytes.count)) begin
                cat[j] = bytes.lane[j-HIST];
            end else begin
                cat[j] = '0;
            end
        end
        for (int k = 0; k < LANES; k++) begin
            for (int b = 0; b < LANES; b++) begin
                win[k][BYTE_W*(LANES-1-b) +: BYTE_W] = cat[k+b];
            end
        end
    end

    // One comparator per candidate ending lane of the new beat.
    for (genvar k = 0; k < LANES; k++) begin : g_cmp
        assign match_vec[k] = (k < int'(bytes.count)) && (win[k] == SYNC_WORD);
    end

    always_comb begin
        hit_pos = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (match_vec[k]) begin
                hit_pos = CNT_W'(k);
            end
        end
        hit = accept && !locked && (|match_vec);
    end

    always_comb begin
        for (int m = 0; m < HIST; m++) begin
            hist_n[m] = cat[int'(bytes.count) + m];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < HIST; m++) begin
                hist_q[m] <= '0;
            end
        end else if (accept && !locked) begin
            for (int m = 0; m < HIST; m++) begin
                hist_q[m] <= hist_n[m];
            end
        end
    end

endmodule

// File: rtl/word_packer.sv
module word_packer
    import sync_align_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                locked,
    input  logic                hit,
    input  logic [CNT_W-1:0]    hit_pos,
    input  beat_bytes_t         bytes,
    output logic                word_valid,
    output logic [WORD_W-1:0]   word_data
);

    byte_t              acc_q [HIST];
    byte_t              acc_n [HIST];
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_n;
    byte_t              mix   [MIX];
    logic               emit;
    logic [WORD_W-1:0]  out_n;
    logic [WORD_W-1:0]  word_q;
    logic               valid_q;
    int                 held;
    int                 total;

    // Held bytes followed by the new beat, in stream order.
    always_comb begin
        held  = int'(cnt_q);
        total = held + int'(bytes.count);
        for (int j = 0; j < MIX; j++) begin
            if (j < held) begin
                mix[j] = acc_q[j];
            end else if ((j - held) < int'(bytes.count)) begin
                mix[j] = bytes.lane[j-held];
            end else begin
                mix[j] = '0;
            end
        end
    end

    always_comb begin
        emit  = 1'b0;
        out_n = word_q;
        cnt_n = cnt_q;
        for (int j = 0; j < HIST; j++) begin
            acc_n[j] = acc_q[j];
        end
        if (hit) begin
            // Bytes after the pattern's last byte open the first word.
            for (int j = 0; j < HIST; j++) begin
                acc_n[j] = ((int'(hit_pos) + 1 + j) < int'(bytes.count))
                         ? bytes.lane[int'(hit_pos) + 1 + j] : '0;
            end
            cnt_n = CNT_W'(int'(bytes.count) - 1 - int'(hit_pos));
        end else if (locked && accept) begin
            if (total >= LANES) begin
                emit = 1'b1;
                for (int b = 0; b < LANES; b++) begin
                    out_n[BYTE_W*(LANES-1-b) +: BYTE_W] = mix[b];
                end
                for (int j = 0; j < HIST; j++) begin
                    acc_n[j] = mix[LANES + j];
                end
                cnt_n = CNT_W'(total - LANES);
            end else begin
                for (int j = 0; j < HIST; j++) begin
                    acc_n[j] = mix[j];
                end
                cnt_n = CNT_W'(total);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
            word_q  <= '0;
            for (int j = 0; j < HIST; j++) begin
                acc_q[j] <= '0;
            end
        end else begin
            cnt_q   <= cnt_n;
            valid_q <= emit;
            if (emit) begin
                word_q <= out_n;
            end
            for (int j = 0; j < HIST; j++) begin
                acc_q[j] <= acc_n[j];
            end
        end
    end

    assign word_valid = valid_q;
    assign word_data  = word_q;

endmodule

// File: rtl/sync_aligner.sv
module sync_aligner
    import sync_align_pkg::*;
#(
    parameter logic [WORD_W-1:0] SYNC_WORD = SYNC_PATTERN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                width_ok,
    input  logic [1:0]          width_sel,
    input  logic                swap_en,
    input  logic                beat_valid,
    input  logic [WORD_W-1:0]   beat_data,
    output logic                word_valid,
    output logic [WORD_W-1:0]   word_data,
    output logic                synced
);

    beat_bytes_t        bytes;
    logic               accept;
    logic               hit;
    logic [CNT_W-1:0]   hit_pos;
    logic               synced_q;

    assign accept = beat_valid && width_ok;

    beat_unpack u_unpack (
        .width  (bus_width_e'(width_sel)),
        .swap   (swap_en),
        .data   (beat_data),
        .bytes  (bytes)
    );

    sync_hunter #(
        .SYNC_WORD (SYNC_WORD)
    ) u_hunter (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .locked  (synced_q),
        .bytes   (bytes),
        .hit     (hit),
        .hit_pos (hit_pos)
    );

    word_packer u_packer (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .locked     (synced_q),
        .hit        (hit),
        .hit_pos    (hit_pos),
        .bytes      (bytes),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            synced_q <= 1'b0;
        end else if (hit) begin
            synced_q <= 1'b1;
        end
    end

    assign synced = synced_q;

endmodule

// File: rtl/sync_align_checker.sv
module sync_align_checker (
    input logic        clk,
    input logic        rst,
    input logic        width_ok,
    input logic [1:0]  width_sel,
    input logic        beat_valid,
    input logic        word_valid,
    input logic        synced
);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!synced && !word_valid));

    p_quiet_before_lock_r2: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> synced);

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !width_ok |=> (!word_valid && $stable(synced)));

    p_x32_rate_r7: assert property (@(posedge clk) disable iff (rst)
        (synced && beat_valid && width_ok && width_sel[1]) |=> word_valid);

    p_sticky_lock_r8: assert property (@(posedge clk) disable iff (rst)
        synced |=> synced);

    p_no_beat_no_word_r10: assert property (@(posedge clk) disable iff (rst)
        !(beat_valid && width_ok) |=> !word_valid);

endmodule

bind sync_aligner sync_align_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .width_ok   (width_ok),
    .width_sel  (width_sel),
    .beat_valid (beat_valid),
    .word_valid (word_valid),
    .synced     (synced)
);

// File: tb/tb_sync_aligner.sv
module tb_sync_aligner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        width_ok = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic        swap_en = 1'b0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        synced;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_hist;
    bit          m_synced;
    logic [7:0]  m_q[$];

    always #2 clk = ~clk;

    sync_aligner dut (
        .clk        (clk),
        .rst        (rst),
        .width_ok   (width_ok),
        .width_sel  (width_sel),
        .swap_en    (swap_en),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .word_valid (word_valid),
        .word_data  (word_data),
        .synced     (synced)
    );

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic int nbytes();
        return (width_sel == 2'd0) ? 1 : (width_sel == 2'd1) ? 2 : 4;
    endfunction

    task automatic step(input logic v, input logic [31:0] d, input string tag);
        bit          ev;
        logic [31:0] ew;
        int          n;
        logic [7:0]  b;
        ev = 1'b0;
        ew = '0;
        beat_valid = v;
        beat_data  = d;
        if (v && width_ok) begin
            n = nbytes();
            for (int i = 0; i < n; i++) begin
                b = d[8*(n-1-i) +: 8];
                if (swap_en) b = flip(b);
                if (!m_synced) begin
                    m_hist = {m_hist[23:0], b};
                    if (m_hist == 32'hAA995566) m_synced = 1'b1;
                end else begin
                    m_q.push_back(b);
                end
            end
            if (m_q.size() >= 4) begin
                ew = {m_q[0], m_q[1], m_q[2], m_q[3]};
                for (int i = 0; i < 4; i++) void'(m_q.pop_front());
                ev = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        vectors++;
        if (word_valid !== ev || synced !== m_synced || (ev && word_data !== ew)) begin
            fails++;
            $display("FAIL %s: valid=%0b synced=%0b data=%08h, expected valid=%0b synced=%0b data=%08h",
                     tag, word_valid, synced, word_data, ev, m_synced, ew);
        end
        beat_valid = 1'b0;
    endtask

    task automatic feed(input logic [7:0] bs[$], input bit gaps, input string tag);
        int n;
        logic [31:0] d;
        n = nbytes();
        for (int p = 0; p < bs.size(); p += n) begin
            d = '0;
            for (int i = 0; i < n; i++) begin
                if (p + i < bs.size()) d[8*(n-1-i) +: 8] = bs[p+i];
            end
            step(1'b1, d, tag);
            if (gaps && (p % 3 == 0)) step(1'b0, 32'hDEADBEEF, tag);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        beat_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_hist = '0;
        m_synced = 1'b0;
        m_q.delete();
        vectors++;
        if (word_valid !== 1'b0 || synced !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b synced=%0b, expected 0 0", word_valid, synced);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s[$];
        do_reset();

        // R3: beats before width detection are ignored
        width_sel = 2'd2;
        width_ok = 1'b0;
        step(1'b1, 32'hAA995566, "R3");
        step(1'b1, 32'hAA995566, "R3");
        width_ok = 1'b1;
        step(1'b1, 32'h12345678, "R3");
        step(1'b1, 32'h9ABCDEF0, "R3");

        // R4 R6 R9 R10: x8, false start, gaps
        do_reset();
        width_sel = 2'd0;
        s = '{8'h01, 8'hAA, 8'h99, 8'h55, 8'hAA, 8'h99, 8'h55, 8'h66,
              8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18};
        feed(s, 1'b1, "R4");

        // R4 R7: x16 at odd byte offset
        do_reset();
        width_sel = 2'd1;
        s = '{8'h00, 8'hAA, 8'h99, 8'h55, 8'h66, 8'hC0, 8'hFF, 8'hEE, 8'hDD,
              8'hCC, 8'hBB, 8'hAA, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55, 8'h44};
        feed(s, 1'b0, "R7");

        // R4 R7 R9: x32 at every byte offset
        for (int off = 0; off < 4; off++) begin
            do_reset();
            width_sel = (off == 3) ? 2'd3 : 2'd2;
            s.delete();
            for (int i = 0; i < off; i++) s.push_back(8'hE0 + 8'(i));
            s.push_back(8'hAA); s.push_back(8'h99); s.push_back(8'h55); s.push_back(8'h66);
            for (int i = 0; i < 14; i++) s.push_back(8'(8'h20 + 8'(i * 7 + off)));
            feed(s, 1'b0, "R4");
        end

        // R5: swapped bitstream on x32, pins show 5599AA66
        do_reset();
        width_sel = 2'd2;
        swap_en = 1'b1;
        step(1'b1, 32'h5599AA66, "R5");
        step(1'b1, 32'h80402010, "R5");
        step(1'b1, 32'h01030507, "R5");

        // R5: swapped on x16 at odd offset
        do_reset();
        width_sel = 2'd1;
        s = '{8'h3C, 8'h55, 8'h99, 8'hAA, 8'h66, 8'h01, 8'h02, 8'h04, 8'h08, 8'hF0};
        feed(s, 1'b1, "R5");
        swap_en = 1'b0;

        // R8 R3 R2: pattern after lock is data, width_ok low ignored
        do_reset();
        width_sel = 2'd0;
        s = '{8'hAA, 8'h99, 8'h55, 8'h66, 8'hAA, 8'h99, 8'h55, 8'h66, 8'h5A};
        feed(s, 1'b0, "R8");
        width_ok = 1'b0;
        step(1'b1, 32'h000000A5, "R3");
        step(1'b1, 32'h000000A6, "R3");
        width_ok = 1'b1;
        s = '{8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F};
        feed(s, 1'b0, "R8");

        // R2: no words while hunting on a long stream without the pattern
        do_reset();
        width_sel = 2'd1;
        for (int i = 0; i < 12; i++) step(1'b1, 32'(16'hAA99 ^ 16'(i)), "R2");

        // R10: pure idle after lock
        width_sel = 2'd2;
        step(1'b1, 32'h0000AA99, "R10");
        step(1'b1, 32'h5566ABCD, "R10");
        step(1'b0, 32'h0, "R10");
        step(1'b1, 32'h01234567, "R10");
        step(1'b0, 32'h0, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule